// File: doc/BRIEF.md
# Display Timing Controller Host Register File

This block is the register file that a host processor uses to program a character-based display timing controller. The host first writes a register number into a 5-bit select register. Data writes and data reads then act on the selected register. A separate status read returns a byte whose meaning depends on the chip variant. The timing geometry lives in registers 0 to 11, and the host cannot read these back. The host can read back the start and cursor addresses, the light-pen capture and, in one variant, a scratch test register.

The block decodes every stored register into the fields the timing generator consumes. These fields are horizontal and vertical totals, displayed counts, sync positions and widths, the scanline count, the cursor lines and blink mode, the scan mode, the display skew, the start address and the cursor address. A light-pen strobe samples the timing generator's current refresh address into two read-only registers and raises a flag. Reading either capture register clears that flag.

The `VARIANT` parameter selects one of four behaviours:
- `VAR_PLAIN`: status reads return 0xFF and the skew field is honoured.
- `VAR_STATUS`: has a status register and a test register at 31, and ignores skew.
- `VAR_NOSTAT`: status reads return 0xFF and skew is ignored.
- `VAR_ALIAS`: a status read performs a read of the selected register, and skew is honoured.

Top module: `disp_host_regs`

## Requirements
- R1: A select write stores the low 5 bits of its data byte. The following data writes and reads act on that register number.
- R2: Writes to registers 0 to 15 are stored ANDed with a per-register mask:
  - 0xFF for registers 0 to 3, 13 and 15.
  - 0x7F for registers 4, 6, 7 and 10.
  - 0x1F for registers 5, 9 and 11.
  - 0xFC for register 8.
  - 0x3F for registers 12 and 14.

  Register 3 bits [3:0] give the horizontal sync width and bits [7:4] give the vertical sync width.
- R3: A data read of any register below 12, or of any register from 18 to 30, returns 0x00. Register 31 also returns 0x00 in every variant except `VAR_STATUS`.
- R4: A data read returns its value on `rd_data` in the cycle after `dat_re` is sampled. `rd_data` holds its value until the next read.
- R5: A light-pen strobe stores the high 6 bits of the 14-bit refresh address into register 16, zero-extended. It stores the low 8 bits into register 17 and sets the light-pen flag.
- R6: A data read of register 16 or 17 clears the light-pen flag. A strobe in the same cycle as such a read wins, and the flag stays set.
- R7: In `VAR_STATUS`, a status read returns a byte built as follows: bit 6 is the light-pen flag, bit 5 is `vsync_in`, and all other bits are 0.
- R8: In `VAR_STATUS`, register 31 is a read/write byte. In the other variants, writes to register 31 are ignored.
- R9: In `VAR_ALIAS`, a status read returns what a data read of the selected register would return, with the same side effects. In `VAR_PLAIN` and `VAR_NOSTAT`, a status read returns 0xFF.
- R10: `start_addr` is {register 12[5:0], register 13}. `cursor_addr` is {register 14[5:0], register 15}.
- R11: Register 8 bits [5:4] set `skew_chars`: 01 gives 1, 10 gives 2, and 00 or 11 give 0. `VAR_STATUS` and `VAR_NOSTAT` hold `skew_chars` at 0. `scan_mode` is register 8 bits [1:0].
- R12: Data writes to registers 16, 17 and 18 to 30 change no stored register and no output field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_we | input | 1 | Write strobe for the register-select latch |
| sel_din | input | 8 | Select data; the low 5 bits are kept |
| dat_we | input | 1 | Write strobe for the selected register |
| dat_din | input | 8 | Write data |
| dat_re | input | 1 | Read strobe for the selected register |
| rd_data | output | 8 | Registered read data |
| stat_re | input | 1 | Status read strobe |
| stat_data | output | 8 | Registered status data |
| vsync_in | input | 1 | Vertical sync from the timing generator |
| lpen_stb | input | 1 | Light-pen strobe, one cycle |
| refresh_addr | input | 14 | Current refresh address from the timing generator |
| h_total | output | 8 | Horizontal total |
| h_disp | output | 8 | Characters displayed per line |
| h_sync_pos | output | 8 | Horizontal sync position |
| h_sync_wid | output | 4 | Horizontal sync width |
| v_sync_wid | output | 4 | Vertical sync width in lines |
| v_total | output | 7 | Vertical total in rows |
| v_adj | output | 5 | Vertical total adjust in lines |
| v_disp | output | 7 | Rows displayed |
| v_sync_pos | output | 7 | Vertical sync row |
| scan_mode | output | 2 | Interlace/scan mode |
| skew_chars | output | 2 | Display skew in characters |
| max_line | output | 5 | Last scanline of a row |
| cur_start | output | 5 | Cursor start line |
| cur_blink | output | 2 | Cursor blink mode |
| cur_end | output | 5 | Cursor end line |
| start_addr | output | 14 | Display start address |
| cursor_addr | output | 14 | Cursor address |

## Verification
The bench targets the following corner cases:
- Mask boundaries: if the bench writes 0xFF into a 7-bit or 5-bit register, or into the high half of an address, and the top bits survive, the timing generator would receive an out-of-range field.
- Select truncation: a select byte with high bits set must still land on its low 5 bits. A decoder that ignored the upper select bits, or compared too few of them, would let writes to registers 16 to 30 corrupt registers 0 to 15.
- Light-pen flag race: a strobe in the same cycle as a capture-register read must leave the flag set and must return the old capture value. A design that gave the clear priority would lose a pen hit.
- Variant handling: three variants are instantiated side by side. This exposes status aliasing, the 0xFF status and the suppressed skew field, any of which a wrong variant decode would swap.

// File: rtl/disp_regs_pkg.sv
package disp_regs_pkg;

  typedef enum logic [1:0] {
    VAR_PLAIN  = 2'd0,
    VAR_STATUS = 2'd1,
    VAR_NOSTAT = 2'd2,
    VAR_ALIAS  = 2'd3
  } variant_e;

  // Store mask per register number; hi_mask covers the high half of a refresh address.
  function automatic logic [7:0] wr_mask(input int unsigned idx, input logic [7:0] hi_mask);
    case (idx)
      0, 1, 2, 3, 13, 15: wr_mask = 8'hFF;
      4, 6, 7, 10:        wr_mask = 8'h7F;
      5, 9, 11:           wr_mask = 8'h1F;
      8:                  wr_mask = 8'hFC;
      12, 14:             wr_mask = hi_mask;
      default:            wr_mask = 8'h00;
    endcase
  endfunction

  function automatic logic variant_has_skew(input variant_e v);
    return (v != VAR_STATUS) && (v != VAR_NOSTAT);
  endfunction

endpackage

// File: rtl/disp_reg_bank.sv
module disp_reg_bank
  import disp_regs_pkg::*;
#(
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned NREG    = 16,
  parameter int unsigned RA_W    = 14,
  parameter variant_e    VARIANT = VAR_STATUS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] sel,
  input  logic [7:0]        din,
  output logic [NREG*8-1:0] regs_flat,
  output logic [1:0]        scan_bits,
  output logic [7:0]        test_q
);
  localparam int unsigned HI_W    = RA_W - 8;
  localparam logic [7:0]  HI_MASK = 8'((1 << HI_W) - 1);
  localparam int unsigned MODE_IX = 8;
  localparam int unsigned TEST_IX = (1 << ADDR_W) - 1;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [7:0] MASK = wr_mask(i, HI_MASK);
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (rst)                                q <= '0;
      else if (we && sel == ADDR_W'(i))       q <= din & MASK;
    end
    assign regs_flat[i*8 +: 8] = q;
  end

  // The scan mode bits are masked out of the readable copy but still drive timing.
  always_ff @(posedge clk) begin
    if (rst)                                  scan_bits <= '0;
    else if (we && sel == ADDR_W'(MODE_IX))   scan_bits <= din[1:0];
  end

  if (VARIANT == VAR_STATUS) begin : g_test
    always_ff @(posedge clk) begin
      if (rst)                                test_q <= '0;
      else if (we && sel == ADDR_W'(TEST_IX)) test_q <= din;
    end
  end else begin : g_no_test
    assign test_q = '0;
  end

endmodule

// File: rtl/disp_lpen_latch.sv
module disp_lpen_latch #(
  parameter int unsigned RA_W = 14
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stb,
  input  logic [RA_W-1:0] ra,
  input  logic            clr,
  output logic [7:0]      hi_q,
  output logic [7:0]      lo_q,
  output logic            flag_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q   <= '0;
      lo_q   <= '0;
      flag_q <= 1'b0;
    end else begin
      if (stb) begin
        hi_q <= 8'(ra[RA_W-1:8]);
        lo_q <= ra[7:0];
      end
      // A new capture outranks a clearing read in the same cycle.
      if (stb)      flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/disp_read_port.sv
module disp_read_port
  import disp_regs_pkg::*;
#(
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned NREG    = 16,
  parameter variant_e    VARIANT = VAR_STATUS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dat_re,
  input  logic              stat_re,
  input  logic [ADDR_W-1:0] sel,
  input  logic [NREG*8-1:0] regs_flat,
  input  logic [7:0]        lpen_hi,
  input  logic [7:0]        lpen_lo,
  input  logic [7:0]        test_q,
  input  logic              lpen_flag,
  input  logic              vsync,
  output logic              clr_lpen,
  output logic [7:0]        rd_data,
  output logic [7:0]        stat_data
);
  localparam int unsigned FIRST_RD = 12;
  localparam int unsigned LPEN_HI  = 16;
  localparam int unsigned LPEN_LO  = 17;
  localparam int unsigned TEST_IX  = (1 << ADDR_W) - 1;
  localparam logic        IS_ALIAS = (VARIANT == VAR_ALIAS);

  logic [7:0] rd_val;
  logic [7:0] stat_val;
  logic       sel_is_lpen;

  always_comb begin
    rd_val = 8'h00;
    if (sel >= ADDR_W'(FIRST_RD) && sel < ADDR_W'(NREG)) rd_val = regs_flat[sel*8 +: 8];
    else if (sel == ADDR_W'(LPEN_HI))                    rd_val = lpen_hi;
    else if (sel == ADDR_W'(LPEN_LO))                    rd_val = lpen_lo;
    else if (sel == ADDR_W'(TEST_IX))                    rd_val = test_q;
  end

  if (VARIANT == VAR_STATUS) begin : g_stat
    assign stat_val = {1'b0, lpen_flag, vsync, 5'b0};
  end else if (VARIANT == VAR_ALIAS) begin : g_alias
    assign stat_val = rd_val;
  end else begin : g_none
    assign stat_val = 8'hFF;
  end

  assign sel_is_lpen = (sel == ADDR_W'(LPEN_HI)) || (sel == ADDR_W'(LPEN_LO));
  assign clr_lpen    = (dat_re || (IS_ALIAS && stat_re)) && sel_is_lpen;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data   <= '0;
      stat_data <= '0;
    end else begin
      if (dat_re)  rd_data   <= rd_val;
      if (stat_re) stat_data <= stat_val;
    end
  end
endmodule

// File: rtl/disp_host_regs.sv
module disp_host_regs
  import disp_regs_pkg::*;
#(
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned RA_W    = 14,
  parameter variant_e    VARIANT = VAR_STATUS
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sel_we,
  input  logic [7:0]      sel_din,
  input  logic            dat_we,
  input  logic [7:0]      dat_din,
  input  logic            dat_re,
  output logic [7:0]      rd_data,
  input  logic            stat_re,
  output logic [7:0]      stat_data,
  input  logic            vsync_in,
  input  logic            lpen_stb,
  input  logic [RA_W-1:0] refresh_addr,
  output logic [7:0]      h_total,
  output logic [7:0]      h_disp,
  output logic [7:0]      h_sync_pos,
  output logic [3:0]      h_sync_wid,
  output logic [3:0]      v_sync_wid,
  output logic [6:0]      v_total,
  output logic [4:0]      v_adj,
  output logic [6:0]      v_disp,
  output logic [6:0]      v_sync_pos,
  output logic [1:0]      scan_mode,
  output logic [1:0]      skew_chars,
  output logic [4:0]      max_line,
  output logic [4:0]      cur_start,
  output logic [1:0]      cur_blink,
  output logic [4:0]      cur_end,
  output logic [RA_W-1:0] start_addr,
  output logic [RA_W-1:0] cursor_addr
);
  localparam int unsigned NREG = 16;
  localparam int unsigned HI_W = RA_W - 8;

  logic [ADDR_W-1:0] sel_q;
  logic [NREG*8-1:0] regs_flat;
  logic [7:0]        r [NREG];
  logic [1:0]        scan_bits;
  logic [7:0]        test_q;
  logic [7:0]        lpen_hi, lpen_lo;
  logic              lpen_flag;
  logic              clr_lpen;

  always_ff @(posedge clk) begin
    if (rst)         sel_q <= '0;
    else if (sel_we) sel_q <= sel_din[ADDR_W-1:0];
  end

  disp_reg_bank #(.ADDR_W(ADDR_W), .NREG(NREG), .RA_W(RA_W), .VARIANT(VARIANT)) u_bank (
    .clk(clk), .rst(rst), .we(dat_we), .sel(sel_q), .din(dat_din),
    .regs_flat(regs_flat), .scan_bits(scan_bits), .test_q(test_q)
  );

  disp_lpen_latch #(.RA_W(RA_W)) u_lpen (
    .clk(clk), .rst(rst), .stb(lpen_stb), .ra(refresh_addr), .clr(clr_lpen),
    .hi_q(lpen_hi), .lo_q(lpen_lo), .flag_q(lpen_flag)
  );

  disp_read_port #(.ADDR_W(ADDR_W), .NREG(NREG), .VARIANT(VARIANT)) u_rd (
    .clk(clk), .rst(rst), .dat_re(dat_re), .stat_re(stat_re), .sel(sel_q),
    .regs_flat(regs_flat), .lpen_hi(lpen_hi), .lpen_lo(lpen_lo), .test_q(test_q),
    .lpen_flag(lpen_flag), .vsync(vsync_in), .clr_lpen(clr_lpen),
    .rd_data(rd_data), .stat_data(stat_data)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_unpack
    assign r[i] = regs_flat[i*8 +: 8];
  end

  assign h_total     = r[0];
  assign h_disp      = r[1];
  assign h_sync_pos  = r[2];
  assign h_sync_wid  = r[3][3:0];
  assign v_sync_wid  = r[3][7:4];
  assign v_total     = r[4][6:0];
  assign v_adj       = r[5][4:0];
  assign v_disp      = r[6][6:0];
  assign v_sync_pos  = r[7][6:0];
  assign scan_mode   = scan_bits;
  assign max_line    = r[9][4:0];
  assign cur_start   = r[10][4:0];
  assign cur_blink   = r[10][6:5];
  assign cur_end     = r[11][4:0];
  assign start_addr  = {r[12][HI_W-1:0], r[13]};
  assign cursor_addr = {r[14][HI_W-1:0], r[15]};

  if (variant_has_skew(VARIANT)) begin : g_skew
    always_comb begin
      case (r[8][5:4])
        2'b01:   skew_chars = 2'd1;
        2'b10:   skew_chars = 2'd2;
        default: skew_chars = 2'd0;
      endcase
    end
  end else begin : g_noskew
    assign skew_chars = 2'd0;
  end

  logic unused_bits;
  assign unused_bits = ^{r[4][7], r[5][7:5], r[6][7], r[7][7], r[8], r[9][7:5],
                         r[10][7], r[11][7:5], r[12][7:HI_W], r[14][7:HI_W]};

endmodule

// File: rtl/disp_host_regs_chk.sv
module disp_host_regs_chk
  import disp_regs_pkg::*;
#(
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned RA_W    = 14,
  parameter variant_e    VARIANT = VAR_STATUS
) (
  input logic              clk,
  input logic              rst,
  input logic              lpen_stb,
  input logic              dat_re,
  input logic              dat_we,
  input logic [7:0]        dat_din,
  input logic              stat_re,
  input logic [ADDR_W-1:0] sel_q,
  input logic              lpen_flag,
  input logic [7:0]        rd_data,
  input logic [7:0]        stat_data,
  input logic [RA_W-1:0]   start_addr,
  input logic [1:0]        skew_chars
);
  localparam logic HAS_SKEW = variant_has_skew(VARIANT);
  localparam logic FF_STAT  = (VARIANT == VAR_PLAIN) || (VARIANT == VAR_NOSTAT);

  p_lpen_sets_flag_r5: assert property (@(posedge clk) disable iff (rst)
    lpen_stb |=> lpen_flag);

  p_lpen_read_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (dat_re && !lpen_stb && (sel_q == ADDR_W'(16) || sel_q == ADDR_W'(17))) |=> !lpen_flag);

  p_low_read_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (dat_re && sel_q < ADDR_W'(12)) |=> rd_data == 8'h00);

  p_start_high_r10: assert property (@(posedge clk) disable iff (rst)
    (dat_we && sel_q == ADDR_W'(12)) |=> start_addr[RA_W-1:8] == $past(dat_din[RA_W-9:0]));

  p_skew_range_r11: assert property (@(posedge clk) disable iff (rst)
    (skew_chars != 2'd3) && (HAS_SKEW || skew_chars == 2'd0));

  p_status_ff_r9: assert property (@(posedge clk) disable iff (rst)
    (FF_STAT && stat_re) |=> stat_data == 8'hFF);

endmodule

bind disp_host_regs disp_host_regs_chk #(.ADDR_W(ADDR_W), .RA_W(RA_W), .VARIANT(VARIANT)) u_chk (
  .clk(clk), .rst(rst), .lpen_stb(lpen_stb), .dat_re(dat_re), .dat_we(dat_we),
  .dat_din(dat_din), .stat_re(stat_re), .sel_q(sel_q), .lpen_flag(lpen_flag),
  .rd_data(rd_data), .stat_data(stat_data), .start_addr(start_addr), .skew_chars(skew_chars)
);

// File: tb/disp_host_regs_tb.sv
module disp_host_regs_tb;
  import disp_regs_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_we = 0, dat_we = 0, dat_re = 0, stat_re = 0, vsync_in = 0, lpen_stb = 0;
  logic [7:0]  sel_din = 0, dat_din = 0;
  logic [13:0] refresh_addr = 0;

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;

  // Outputs of the status variant (u_dut)
  logic [7:0] rd_s, st_s, ht, hd, hsp;
  logic [3:0] hsw, vsw;
  logic [6:0] vt, vd, vsp;
  logic [4:0] va, ml, cs, ce;
  logic [1:0] sm, sk_s, cb;
  logic [13:0] sa, ca;

  // Outputs of the alias (_a) and no-status (_n) variants
  logic [7:0] rd_a, st_a, ht_a, hd_a, hsp_a, rd_n, st_n, ht_n, hd_n, hsp_n;
  logic [3:0] hsw_a, vsw_a, hsw_n, vsw_n;
  logic [6:0] vt_a, vd_a, vsp_a, vt_n, vd_n, vsp_n;
  logic [4:0] va_a, ml_a, cs_a, ce_a, va_n, ml_n, cs_n, ce_n;
  logic [1:0] sm_a, sk_a, cb_a, sm_n, sk_n, cb_n;
  logic [13:0] sa_a, ca_a, sa_n, ca_n;

  disp_host_regs #(.VARIANT(VAR_STATUS)) u_dut (
    .clk, .rst, .sel_we, .sel_din, .dat_we, .dat_din, .dat_re, .rd_data(rd_s),
    .stat_re, .stat_data(st_s), .vsync_in, .lpen_stb, .refresh_addr,
    .h_total(ht), .h_disp(hd), .h_sync_pos(hsp), .h_sync_wid(hsw), .v_sync_wid(vsw),
    .v_total(vt), .v_adj(va), .v_disp(vd), .v_sync_pos(vsp), .scan_mode(sm),
    .skew_chars(sk_s), .max_line(ml), .cur_start(cs), .cur_blink(cb), .cur_end(ce),
    .start_addr(sa), .cursor_addr(ca));

  disp_host_regs #(.VARIANT(VAR_ALIAS)) u_dut_alias (
    .clk, .rst, .sel_we, .sel_din, .dat_we, .dat_din, .dat_re, .rd_data(rd_a),
    .stat_re, .stat_data(st_a), .vsync_in, .lpen_stb, .refresh_addr,
    .h_total(ht_a), .h_disp(hd_a), .h_sync_pos(hsp_a), .h_sync_wid(hsw_a), .v_sync_wid(vsw_a),
    .v_total(vt_a), .v_adj(va_a), .v_disp(vd_a), .v_sync_pos(vsp_a), .scan_mode(sm_a),
    .skew_chars(sk_a), .max_line(ml_a), .cur_start(cs_a), .cur_blink(cb_a), .cur_end(ce_a),
    .start_addr(sa_a), .cursor_addr(ca_a));

  disp_host_regs #(.VARIANT(VAR_NOSTAT)) u_dut_nostat (
    .clk, .rst, .sel_we, .sel_din, .dat_we, .dat_din, .dat_re, .rd_data(rd_n),
    .stat_re, .stat_data(st_n), .vsync_in, .lpen_stb, .refresh_addr,
    .h_total(ht_n), .h_disp(hd_n), .h_sync_pos(hsp_n), .h_sync_wid(hsw_n), .v_sync_wid(vsw_n),
    .v_total(vt_n), .v_adj(va_n), .v_disp(vd_n), .v_sync_pos(vsp_n), .scan_mode(sm_n),
    .skew_chars(sk_n), .max_line(ml_n), .cur_start(cs_n), .cur_blink(cb_n), .cur_end(ce_n),
    .start_addr(sa_n), .cursor_addr(ca_n));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_sel(input logic [7:0] a);
    @(negedge clk); sel_we = 1; sel_din = a;
    @(negedge clk); sel_we = 0;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    wr_sel(a);
    @(negedge clk); dat_we = 1; dat_din = d;
    @(negedge clk); dat_we = 0;
  endtask

  task automatic rd_reg(input logic [7:0] a);
    wr_sel(a);
    @(negedge clk); dat_re = 1;
    @(negedge clk); dat_re = 0;
  endtask

  task automatic rd_stat();
    @(negedge clk); stat_re = 1;
    @(negedge clk); stat_re = 0;
  endtask

  task automatic t_reset();
    chk("R4 reset rd_data", rd_s, 0);
    chk("R7 reset stat_data", st_s, 0);
    chk("R10 reset start_addr", sa, 0);
    chk("R11 reset skew", sk_a, 0);
  endtask

  task automatic t_masks();
    wr_reg(4, 8'hFF);  chk("R2 v_total mask", vt, 7'h7F);
    wr_reg(9, 8'hFF);  chk("R2 max_line mask", ml, 5'h1F);
    wr_reg(3, 8'hA5);  chk("R2 h_sync_wid", hsw, 4'h5);
    chk("R2 v_sync_wid", vsw, 4'hA);
    wr_reg(10, 8'hFF); chk("R2 cursor blink", cb, 2'd3);
    chk("R2 cursor start", cs, 5'h1F);
    wr_reg(12, 8'hFF); rd_reg(12); chk("R2 reg12 mask", rd_s, 8'h3F);
    wr_reg(13, 8'h5A); rd_reg(13); chk("R2 reg13 full", rd_s, 8'h5A);
  endtask

  task automatic t_addr();
    wr_reg(12, 8'h2B); wr_reg(13, 8'hC4);
    chk("R10 start_addr", sa, 14'h2BC4);
    wr_reg(14, 8'hD1); wr_reg(15, 8'h22);
    chk("R10 cursor_addr", ca, 14'h1122);
    rd_reg(14); chk("R10 reg14 read", rd_s, 8'h11);
  endtask

  task automatic t_latency();
    rd_reg(15); chk("R4 read reg15", rd_s, 8'h22);
    wr_sel(13);
    @(negedge clk); dat_re = 1;
    #1 chk("R4 old value before edge", rd_s, 8'h22);
    @(negedge clk); dat_re = 0;
    chk("R4 new value after edge", rd_s, 8'hC4);
    repeat (3) @(negedge clk);
    chk("R4 value held", rd_s, 8'hC4);
  endtask

  task automatic t_select();
    wr_reg(8'hEC, 8'h07);
    chk("R1 select low five bits", sa, 14'h07C4);
  endtask

  task automatic t_zero_reads();
    wr_reg(0, 8'h55); chk("R2 h_total", ht, 8'h55);
    rd_reg(0);  chk("R3 read reg0", rd_s, 0);
    rd_reg(11); chk("R3 read reg11", rd_s, 0);
    rd_reg(20); chk("R3 read reg20", rd_s, 0);
  endtask

  task automatic t_lpen();
    @(negedge clk); refresh_addr = 14'h3A5C; lpen_stb = 1;
    @(negedge clk); lpen_stb = 0;
    rd_stat(); chk("R7 status flag", st_s, 8'h40);
    vsync_in = 1;
    rd_stat(); chk("R7 status vsync", st_s, 8'h60);
    vsync_in = 0;
    rd_reg(16); chk("R5 capture high", rd_s, 8'h3A);
    rd_stat(); chk("R6 flag cleared", st_s, 8'h00);
    rd_reg(17); chk("R5 capture low", rd_s, 8'h5C);
    // strobe and capture read collide
    @(negedge clk); refresh_addr = 14'h0123; lpen_stb = 1; dat_re = 1;
    @(negedge clk); lpen_stb = 0; dat_re = 0;
    chk("R6 collision old value", rd_s, 8'h5C);
    rd_stat(); chk("R6 strobe wins", st_s, 8'h40);
    rd_reg(17); chk("R5 new low", rd_s, 8'h23);
    rd_stat(); chk("R6 cleared again", st_s, 8'h00);
  endtask

  task automatic t_test_reg();
    wr_reg(31, 8'h9E);
    rd_reg(31);
    chk("R8 test reg status variant", rd_s, 8'h9E);
    chk("R8 test reg absent alias", rd_a, 8'h00);
    chk("R3 reg31 reads zero", rd_n, 8'h00);
  endtask

  task automatic t_ignore();
    wr_reg(16, 8'hFF); rd_reg(16);
    chk("R12 reg16 not writable", rd_s, 8'h01);
    wr_reg(20, 8'h00);
    chk("R12 reg20 write no alias to reg4", vt, 7'h7F);
    wr_reg(28, 8'h00);
    chk("R12 reg28 write no alias to reg12", sa, 14'h07C4);
  endtask

  task automatic t_alias();
    wr_sel(13); rd_stat();
    chk("R9 alias status reads reg", st_a, 8'hC4);
    chk("R9 no-status variant 0xFF", st_n, 8'hFF);
    chk("R7 status variant", st_s, 8'h00);
  endtask

  task automatic t_skew();
    wr_reg(8, 8'h10);
    chk("R11 skew one", sk_a, 2'd1);
    chk("R11 skew ignored status", sk_s, 2'd0);
    chk("R11 skew ignored nostat", sk_n, 2'd0);
    wr_reg(8, 8'h23);
    chk("R11 skew two", sk_a, 2'd2);
    chk("R11 scan mode", sm, 2'd3);
    wr_reg(8, 8'h30);
    chk("R11 skew code 3", sk_a, 2'd0);
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_masks();
    t_addr();
    t_latency();
    t_select();
    t_zero_reads();
    t_lpen();
    t_test_reg();
    t_ignore();
    t_alias();
    t_skew();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule